// File: doc/BRIEF.md
# SPI flash command engine

This block is a byte-addressed controller that runs one serial-flash command at a time. Software places an opcode byte in a dedicated register, packs the number of bytes to send and the number of bytes to receive into a counts register, and fills an eight-entry byte FIFO with the data bytes that follow the opcode. Writing the start bit in the control register then opens a frame: chip select falls, the opcode goes out first, the FIFO bytes follow, and after them the engine clocks in the reply bytes and stores them in the same FIFO, right behind the data it just sent.

The FIFO has one software pointer that steps on every access to the data port, read or write, and a control bit that clears that pointer. A driver therefore clears the pointer before loading, before starting and before reading back, and on read-back it skips over its own transmit bytes to reach the reply. A command that sends no data bytes carries a receive count that is one larger than the reply it wants; the engine drops that extra byte so that the reply still starts at FIFO entry zero. While a command runs, the register state that the engine depends on is locked against changes.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset every register reads 0x00, chip select is high, and the serial clock and the serial data output are low.
- R2: The opcode register (address 0x0) and the counts register (address 0x1) read back the last value written while idle; an address with no register reads 0x00.
- R3: Each read or write of the data port (address 0xC) uses the FIFO entry at the pointer and then advances the pointer by one, wrapping from 7 to 0; address 0xD bits [2:0] return the pointer, and writing 1 to bit 4 of the control register (address 0x2) clears it.
- R4: Writing 1 to bit 0 of the control register starts a command; control bit 0 and bit 7 of the status register (address 0x3) both read 1 from the start until the frame has ended, then read 0.
- R5: Chip select stays low for the whole frame; the opcode register value is sent first, then FIFO entries 0 upward, one per transmit byte, where the transmit count is counts bits [3:0] and a value above 8 is treated as 8.
- R6: After the transmit bytes the engine clocks in the receive count (counts bits [7:4]) of bytes with the serial data output held low, and stores reply byte k at FIFO entry (transmit count + k) mod 8.
- R7: When counts bits [3:0] are zero, the engine receives one byte fewer than counts bits [7:4] (none for a receive count of 0 or 1), and the first reply byte lands in FIFO entry 0.
- R8: Bytes move most significant bit first in clock mode 0: the serial clock idles low, output data changes only while the clock is low, input data is taken on the rising edge, and one clock period lasts 2*HALF_DIV system clocks.
- R9: While a command runs, writes to the opcode, counts and data port, a pointer clear and a second start are all ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access; advances the pointer on the data port |
| bus_rdata | output | 8 | Read data for bus_addr, valid in the same cycle |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The command path is driven with a table of count combinations: data-only, mixed send and receive, receive-only with the one-byte allowance (including receive counts of 0 and 1), a reply long enough to wrap the FIFO over the transmit bytes, and a transmit count above eight. Comparing the captured bus bytes against the read-back FIFO separates a wrong transmit order, a wrong reply offset, a missing off-by-one drop and a missing clamp, because each of those shifts a different set of bytes. A serial responder that returns a distinct value for every byte position in the frame makes any slip of one byte visible. Directed cases cover the pointer wrap and clear, the lockout during a running command and the serial clock period.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

  // Width of a packed count field in the counts register.
  localparam int unsigned CNT_W = 4;

  // Register byte addresses.
  localparam logic [3:0] A_OPCODE = 4'h0;
  localparam logic [3:0] A_COUNTS = 4'h1;
  localparam logic [3:0] A_CTRL   = 4'h2;
  localparam logic [3:0] A_STAT   = 4'h3;
  localparam logic [3:0] A_DATA   = 4'hC;
  localparam logic [3:0] A_PTR    = 4'hD;

  // Bit positions inside the control and status registers.
  localparam int unsigned CTRL_GO   = 0;
  localparam int unsigned CTRL_PCLR = 4;
  localparam int unsigned STAT_BUSY = 7;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LAUNCH,
    SQ_WAIT,
    SQ_FINISH
  } sq_state_e;

  typedef enum logic [1:0] {
    PH_OPC,
    PH_TX,
    PH_RX
  } sq_phase_e;

  // Number of data bytes actually sent for a requested count.
  function automatic logic [CNT_W-1:0] clamp_tx(input logic [CNT_W-1:0] req,
                                                input logic [CNT_W-1:0] cap);
    return (req > cap) ? cap : req;
  endfunction

  // Number of reply bytes actually clocked in. A command with no data bytes
  // is programmed one higher than the reply it wants.
  function automatic logic [CNT_W-1:0] rx_effective(input logic [CNT_W-1:0] tx_req,
                                                    input logic [CNT_W-1:0] rx_req);
    if (tx_req == '0) begin
      return (rx_req == '0) ? '0 : rx_req - 1'b1;
    end
    return rx_req;
  endfunction

  // Next FIFO slot with an explicit wrap at the depth.
  function automatic int unsigned slot_next(input int unsigned idx,
                                            input int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/spi_cmd_fifo.sv
`timescale 1ns/1ps
module spi_cmd_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned BW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ptr_clr,
  input  logic                     ptr_step,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [BW-1:0]            wr_data,
  input  logic [$clog2(DEPTH)-1:0] eng_idx,
  output logic [BW-1:0]            eng_data,
  output logic [$clog2(DEPTH)-1:0] ptr,
  output logic [BW-1:0]            ptr_data
);
  import spi_cmd_pkg::*;

  localparam int unsigned PW = $clog2(DEPTH);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [BW-1:0] mem_q [DEPTH];
  logic [PW-1:0] ptr_q;

  // One register per entry, written from the shared write port.
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (wr_en && (wr_idx == PW'(g))) begin
        mem_q[g] <= wr_data;
      end
    end
  end

  // Software pointer: clear wins over step, step wraps at the depth.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_clr) begin
      ptr_q <= '0;
    end else if (ptr_step) begin
      ptr_q <= PW'(slot_next(int'(ptr_q), DEPTH));
    end
  end

  assign ptr      = ptr_q;
  assign ptr_data = mem_q[ptr_q];
  assign eng_data = mem_q[eng_idx];

  // R3: stepping from the last slot lands on slot zero.
  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && !ptr_clr && ptr_q == PTR_LAST) |=> (ptr_q == '0));

  // R3: a clear request leaves the pointer at zero.
  p_ptr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (ptr_q == '0));

  // R3: without a request the pointer holds.
  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_clr && !ptr_step) |=> $stable(ptr_q));

endmodule

// File: rtl/spi_cmd_shifter.sv
`timescale 1ns/1ps
module spi_cmd_shifter #(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned BW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [BW-1:0] tx_byte,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [BW-1:0] rx_byte,
  output logic          active
);

  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int unsigned BIT_W = $clog2(BW);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BW - 1);

  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic [BW-1:0]    out_q;
  logic [BW-1:0]    in_q;
  logic             sck_q;
  logic             mosi_q;
  logic             done_q;
  logic             act_q;

  // Named internal events.
  logic half_tick;
  logic rise_evt;
  logic fall_evt;
  logic last_fall;

  assign half_tick = act_q && (div_q == DIV_LAST);
  assign rise_evt  = half_tick && !sck_q;
  assign fall_evt  = half_tick && sck_q;
  assign last_fall = fall_evt && (bit_q == BIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bit_q  <= '0;
      out_q  <= '0;
      in_q   <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        act_q  <= 1'b1;
        div_q  <= '0;
        bit_q  <= '0;
        out_q  <= tx_byte;
        mosi_q <= tx_byte[BW-1];
        sck_q  <= 1'b0;
      end else if (act_q) begin
        div_q <= half_tick ? '0 : div_q + 1'b1;
        if (rise_evt) begin
          sck_q <= 1'b1;
          in_q  <= {in_q[BW-2:0], miso};
        end
        if (fall_evt) begin
          sck_q <= 1'b0;
          if (last_fall) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
            mosi_q <= 1'b0;
          end else begin
            bit_q  <= bit_q + 1'b1;
            out_q  <= {out_q[BW-2:0], 1'b0};
            mosi_q <= out_q[BW-2];
          end
        end
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign done    = done_q;
  assign rx_byte = in_q;
  assign active  = act_q;

  // R8: output data moves only while the serial clock is low.
  p_mosi_clk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_q) |-> !sck_q);

  // R8: the serial clock idles low between bytes.
  p_sck_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !start) |=> !sck_q || act_q);

  // R8: a byte completes right after a falling clock edge.
  p_done_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(sck_q) && !sck_q));

endmodule

// File: rtl/spi_cmd_seq.sv
`timescale 1ns/1ps
module spi_cmd_seq #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned BW     = 8,
  parameter int unsigned MAX_TX = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               go,
  input  logic [BW-1:0]                      opcode,
  input  logic [spi_cmd_pkg::CNT_W-1:0]      tx_req,
  input  logic [spi_cmd_pkg::CNT_W-1:0]      rx_req,
  input  logic [BW-1:0]                      fifo_data,
  output logic [$clog2(DEPTH)-1:0]           fifo_idx,
  output logic                               rx_we,
  output logic [BW-1:0]                      rx_data,
  output logic                               sh_start,
  output logic [BW-1:0]                      sh_byte,
  input  logic                               sh_done,
  input  logic [BW-1:0]                      sh_rx,
  output logic                               cs_n,
  output logic                               running
);
  import spi_cmd_pkg::*;

  localparam int unsigned PW = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] TX_CAP = CNT_W'(MAX_TX);

  sq_state_e        state_q;
  sq_phase_e        phase_q;
  logic [CNT_W-1:0] tx_left_q;
  logic [CNT_W-1:0] rx_left_q;
  logic [PW-1:0]    idx_q;
  logic             cs_n_q;
  logic             run_q;

  // Counts remaining once the byte in flight is accounted for.
  logic [CNT_W-1:0] tx_after;
  logic [CNT_W-1:0] rx_after;
  logic             byte_end;

  assign byte_end = (state_q == SQ_WAIT) && sh_done;
  assign tx_after = (phase_q == PH_TX) ? tx_left_q - 1'b1 : tx_left_q;
  assign rx_after = (phase_q == PH_RX) ? rx_left_q - 1'b1 : rx_left_q;

  always_comb begin
    case (phase_q)
      PH_OPC:  sh_byte = opcode;
      PH_TX:   sh_byte = fifo_data;
      default: sh_byte = '0;
    endcase
  end

  assign sh_start = (state_q == SQ_LAUNCH);
  assign rx_we    = byte_end && (phase_q == PH_RX);
  assign rx_data  = sh_rx;
  assign fifo_idx = idx_q;
  assign cs_n     = cs_n_q;
  assign running  = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SQ_IDLE;
      phase_q   <= PH_OPC;
      tx_left_q <= '0;
      rx_left_q <= '0;
      idx_q     <= '0;
      cs_n_q    <= 1'b1;
      run_q     <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (go) begin
            cs_n_q    <= 1'b0;
            run_q     <= 1'b1;
            phase_q   <= PH_OPC;
            tx_left_q <= clamp_tx(tx_req, TX_CAP);
            rx_left_q <= rx_effective(tx_req, rx_req);
            idx_q     <= '0;
            state_q   <= SQ_LAUNCH;
          end
        end
        SQ_LAUNCH: state_q <= SQ_WAIT;
        SQ_WAIT: begin
          if (sh_done) begin
            if (phase_q != PH_OPC) begin
              idx_q <= PW'(slot_next(int'(idx_q), DEPTH));
            end
            tx_left_q <= tx_after;
            rx_left_q <= rx_after;
            if (tx_after != '0) begin
              phase_q <= PH_TX;
              state_q <= SQ_LAUNCH;
            end else if (rx_after != '0) begin
              phase_q <= PH_RX;
              state_q <= SQ_LAUNCH;
            end else begin
              state_q <= SQ_FINISH;
            end
          end
        end
        default: begin
          cs_n_q  <= 1'b1;
          run_q   <= 1'b0;
          state_q <= SQ_IDLE;
        end
      endcase
    end
  end

  // R5: every byte is launched inside an open frame.
  p_start_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> !cs_n_q);

  // R6: reply bytes are stored only after all transmit bytes have gone.
  p_rx_after_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (tx_left_q == '0) && run_q);

  // R4: the running flag drops only as the frame closes.
  p_run_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $rose(cs_n_q));

endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine #(
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned MAX_TX     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  import spi_cmd_pkg::*;

  localparam int unsigned BW = 8;
  localparam int unsigned PW = $clog2(FIFO_DEPTH);

  logic [BW-1:0] opcode_q;
  logic [BW-1:0] counts_q;
  logic          busy;

  // Named bus events.
  logic host_go;
  logic host_pclr;
  logic host_dwr;
  logic host_drd;

  assign host_go   = bus_wr && (bus_addr == A_CTRL) && bus_wdata[CTRL_GO]   && !busy;
  assign host_pclr = bus_wr && (bus_addr == A_CTRL) && bus_wdata[CTRL_PCLR] && !busy;
  assign host_dwr  = bus_wr && (bus_addr == A_DATA) && !busy;
  assign host_drd  = bus_rd && !bus_wr && (bus_addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= '0;
      counts_q <= '0;
    end else if (bus_wr && !busy) begin
      if (bus_addr == A_OPCODE) opcode_q <= bus_wdata;
      if (bus_addr == A_COUNTS) counts_q <= bus_wdata;
    end
  end

  // FIFO and its write-port sharing.
  logic [PW-1:0] ptr;
  logic [BW-1:0] ptr_data;
  logic [PW-1:0] eng_idx;
  logic [BW-1:0] eng_data;
  logic          eng_we;
  logic [BW-1:0] eng_wdata;
  logic          fifo_we;
  logic [PW-1:0] fifo_widx;
  logic [BW-1:0] fifo_wdata;

  assign fifo_we    = busy ? eng_we    : host_dwr;
  assign fifo_widx  = busy ? eng_idx   : ptr;
  assign fifo_wdata = busy ? eng_wdata : bus_wdata;

  spi_cmd_fifo #(
    .DEPTH (FIFO_DEPTH),
    .BW    (BW)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_clr  (host_pclr),
    .ptr_step (host_dwr || host_drd),
    .wr_en    (fifo_we),
    .wr_idx   (fifo_widx),
    .wr_data  (fifo_wdata),
    .eng_idx  (eng_idx),
    .eng_data (eng_data),
    .ptr      (ptr),
    .ptr_data (ptr_data)
  );

  // Sequencer and shifter.
  logic          sh_start;
  logic [BW-1:0] sh_byte;
  logic          sh_done;
  logic [BW-1:0] sh_rx;
  logic          sh_active;

  spi_cmd_seq #(
    .DEPTH  (FIFO_DEPTH),
    .BW     (BW),
    .MAX_TX (MAX_TX)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (host_go),
    .opcode    (opcode_q),
    .tx_req    (counts_q[CNT_W-1:0]),
    .rx_req    (counts_q[2*CNT_W-1:CNT_W]),
    .fifo_data (eng_data),
    .fifo_idx  (eng_idx),
    .rx_we     (eng_we),
    .rx_data   (eng_wdata),
    .sh_start  (sh_start),
    .sh_byte   (sh_byte),
    .sh_done   (sh_done),
    .sh_rx     (sh_rx),
    .cs_n      (spi_cs_n),
    .running   (busy)
  );

  spi_cmd_shifter #(
    .HALF_DIV (HALF_DIV),
    .BW       (BW)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (sh_start),
    .tx_byte (sh_byte),
    .miso    (spi_miso),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .done    (sh_done),
    .rx_byte (sh_rx),
    .active  (sh_active)
  );

  // Read mux.
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_OPCODE: bus_rdata = opcode_q;
      A_COUNTS: bus_rdata = counts_q;
      A_CTRL:   bus_rdata[CTRL_GO] = busy;
      A_STAT:   bus_rdata[STAT_BUSY] = busy;
      A_DATA:   bus_rdata = ptr_data;
      A_PTR:    bus_rdata = {{(BW-PW){1'b0}}, ptr};
      default:  bus_rdata = '0;
    endcase
  end

  // R9: a write to the opcode register during a command changes nothing.
  p_opcode_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == A_OPCODE) |=> $stable(opcode_q));

  // R9: a write to the counts register during a command changes nothing.
  p_counts_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == A_COUNTS) |=> $stable(counts_q));

  // R9: a pointer clear during a command leaves the pointer alone.
  p_pclr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == A_CTRL) |=> $stable(ptr));

  // R4: a command starts only from a software start request.
  p_busy_from_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_wr && bus_addr == A_CTRL && bus_wdata[CTRL_GO]));

  // R5: the shifter only runs inside an open frame.
  p_shift_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sh_active |-> !spi_cs_n);

endmodule

// File: tb/test_spi_cmd_engine.sv
`timescale 1ns/1ps
module test_spi_cmd_engine;

  localparam int HALF   = 2;
  localparam int CLK_NS = 8;

  localparam logic [3:0] R_OPC  = 4'h0;
  localparam logic [3:0] R_CNT  = 4'h1;
  localparam logic [3:0] R_CTL  = 4'h2;
  localparam logic [3:0] R_STA  = 4'h3;
  localparam logic [3:0] R_DAT  = 4'hC;
  localparam logic [3:0] R_PTR  = 4'hD;

  // {opcode, counts (rx<<4 | tx), responder seed}
  localparam int NVEC = 7;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h03_43_5A,
    24'h02_08_C3,
    24'h9F_40_17,
    24'h05_10_E8,
    24'h0B_65_2D,
    24'h06_00_71,
    24'hAB_2C_94
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       spi_sck;
  logic       spi_cs_n;
  logic       spi_mosi;
  logic       spi_miso;

  always #(CLK_NS/2) clk = ~clk;

  spi_cmd_engine #(.HALF_DIV(HALF)) i_spi_cmd_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .spi_sck   (spi_sck),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- serial responder ----------------
  logic [7:0] seed = '0;
  int unsigned rise_cnt = 0;
  int unsigned frame_base = 0;
  int unsigned cs_falls = 0;
  logic [7:0] shift_cap = '0;
  logic [7:0] cap_bytes [32];
  realtime last_rise = 0;
  realtime sck_period = 0;

  function automatic logic [7:0] resp(input logic [7:0] s, input int b);
    return (s ^ 8'(b * 59)) + 8'h11;
  endfunction

  function automatic logic miso_bit(input logic [7:0] s, input int unsigned pos);
    logic [7:0] v;
    v = resp(s, int'(pos / 8));
    return v[7 - (pos % 8)];
  endfunction

  assign spi_miso = spi_cs_n ? 1'b0 : miso_bit(seed, rise_cnt - frame_base);

  always @(negedge spi_cs_n) begin
    frame_base = rise_cnt;
    cs_falls++;
  end

  always @(posedge spi_sck) begin
    int unsigned pos;
    logic [7:0] nxt;
    pos = rise_cnt - frame_base;
    nxt = {shift_cap[6:0], spi_mosi};
    shift_cap = nxt;
    if (pos % 8 != 0) sck_period = $realtime - last_rise;
    last_rise = $realtime;
    if (pos % 8 == 7) cap_bytes[(pos / 8) % 32] = nxt;
    rise_cnt++;
  end

  // ---------------- bus tasks ----------------
  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] d;
    bit idle;
    idle = 0;
    for (int n = 0; n < 4000; n++) begin
      bus_read(R_CTL, d);
      if (!d[0]) begin idle = 1; break; end
    end
    check({tag, " command completes"}, {31'd0, idle}, 32'd1);
  endtask

  function automatic logic [7:0] txd(input logic [7:0] opc, input int i);
    return opc + 8'(i * 17) + 8'h30;
  endfunction

  // One full driver sequence: load, run, compare bus bytes and read-back.
  task automatic run_cmd(input logic [7:0] opc, input logic [7:0] cnt, input logic [7:0] sd);
    logic [7:0] img [8];
    logic [7:0] d;
    int tx_req, rx_req, tx_n, rx_n;
    tx_req = int'(cnt[3:0]);
    rx_req = int'(cnt[7:4]);
    tx_n = (tx_req > 8) ? 8 : tx_req;                       // R5 clamp
    if (tx_req == 0) rx_n = (rx_req > 0) ? rx_req - 1 : 0;  // R7
    else rx_n = rx_req;                                     // R6
    for (int i = 0; i < 8; i++) img[i] = '0;
    seed = sd;
    bus_write(R_CTL, 8'h10);
    bus_write(R_OPC, opc);
    bus_write(R_CNT, cnt);
    for (int i = 0; i < tx_req; i++) begin
      bus_write(R_DAT, txd(opc, i));
      img[i % 8] = txd(opc, i);
    end
    bus_write(R_CTL, 8'h10);
    bus_write(R_CTL, 8'h01);
    wait_idle("R4");
    check("R5 frame byte count", (rise_cnt - frame_base) / 8, 1 + tx_n + rx_n);
    check("R5 opcode first", {24'd0, cap_bytes[0]}, {24'd0, opc});
    for (int i = 0; i < tx_n; i++)
      check("R5 transmit byte", {24'd0, cap_bytes[1 + i]}, {24'd0, img[i]});
    for (int k = 0; k < rx_n; k++) begin
      check("R6 output low in receive", {24'd0, cap_bytes[1 + tx_n + k]}, 32'd0);
      img[(tx_n + k) % 8] = resp(sd, 1 + tx_n + k);
    end
    check("R5 frame closed", {31'd0, spi_cs_n}, 32'd1);
    bus_write(R_CTL, 8'h10);
    for (int j = 0; j < tx_n + rx_n; j++) begin
      bus_read(R_DAT, d);
      if (j >= tx_n && tx_req == 0)
        check("R7 reply aligned", {24'd0, d}, {24'd0, img[j % 8]});
      else
        check("R6 read-back", {24'd0, d}, {24'd0, img[j % 8]});
    end
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] d;
    int falls_before;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 chip select high", {31'd0, spi_cs_n}, 32'd1);
    check("R1 clock low", {31'd0, spi_sck}, 32'd0);
    check("R1 data out low", {31'd0, spi_mosi}, 32'd0);
    rst_n = 1'b1;
    bus_read(R_OPC, d); check("R1 opcode reg", {24'd0, d}, 32'd0);
    bus_read(R_CNT, d); check("R1 counts reg", {24'd0, d}, 32'd0);
    bus_read(R_CTL, d); check("R1 control reg", {24'd0, d}, 32'd0);
    bus_read(R_STA, d); check("R1 status reg", {24'd0, d}, 32'd0);
    bus_read(R_PTR, d); check("R1 pointer reg", {24'd0, d}, 32'd0);

    // R2: register readback and unmapped address
    bus_write(R_OPC, 8'h5A);
    bus_read(R_OPC, d); check("R2 opcode readback", {24'd0, d}, 32'h5A);
    bus_write(R_CNT, 8'hC3);
    bus_read(R_CNT, d); check("R2 counts readback", {24'd0, d}, 32'hC3);
    bus_read(4'h7, d); check("R2 unmapped reads zero", {24'd0, d}, 32'd0);

    // R3: pointer stepping, wrap and clear
    bus_write(R_CTL, 8'h10);
    for (int i = 0; i < 9; i++) bus_write(R_DAT, 8'h80 + 8'(i));
    bus_read(R_PTR, d); check("R3 pointer wraps after 9 writes", {24'd0, d}, 32'd1);
    bus_read(R_DAT, d); check("R3 read at slot 1", {24'd0, d}, 32'h81);
    bus_read(R_PTR, d); check("R3 read advances pointer", {24'd0, d}, 32'd2);
    bus_write(R_CTL, 8'h10);
    bus_read(R_PTR, d); check("R3 pointer clear", {24'd0, d}, 32'd0);
    bus_read(R_DAT, d); check("R3 slot 0 overwritten by wrap", {24'd0, d}, 32'h88);

    // Table of command vectors
    for (int v = 0; v < NVEC; v++) begin
      run_cmd(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
    end

    // R8: clock period and idle level
    check("R8 clock period", int'(sck_period), 2 * HALF * CLK_NS);
    check("R8 clock idles low", {31'd0, spi_sck}, 32'd0);

    // R4 and R9: status while running and lockout
    seed = 8'h3C;
    bus_write(R_CTL, 8'h10);
    bus_write(R_OPC, 8'h3B);
    bus_write(R_CNT, 8'h82);
    bus_write(R_DAT, 8'h11);
    bus_write(R_DAT, 8'h22);
    falls_before = int'(cs_falls);
    bus_write(R_CTL, 8'h01);
    repeat (4) @(posedge clk);
    bus_read(R_STA, d); check("R4 busy bit while running", {24'd0, d}, 32'h80);
    bus_read(R_CTL, d); check("R4 start bit while running", {24'd0, d}, 32'h01);
    bus_write(R_OPC, 8'hEE);
    bus_write(R_CNT, 8'h00);
    bus_write(R_DAT, 8'h77);
    bus_write(R_CTL, 8'h11);
    bus_read(R_PTR, d); check("R9 pointer untouched while busy", {24'd0, d}, 32'd2);
    wait_idle("R9");
    bus_read(R_STA, d); check("R4 busy bit clears", {24'd0, d}, 32'd0);
    bus_read(R_OPC, d); check("R9 opcode kept", {24'd0, d}, 32'h3B);
    bus_read(R_CNT, d); check("R9 counts kept", {24'd0, d}, 32'h82);
    check("R9 frame length unchanged", (rise_cnt - frame_base) / 8, 11);
    check("R9 single frame opened", int'(cs_falls) - falls_before, 1);
    check("R5 opcode of locked command", {24'd0, cap_bytes[0]}, 32'h3B);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule